// File: doc/BRIEF.md
# Multi-Slot In-Order Retire Queue

This block is a circular reorder queue for an out-of-order core. At dispatch, each instruction claims a run of consecutive slots. The length of the run is its micro-op count, forced into the range one to the queue depth. A zero micro-op instruction therefore still holds one slot. The index of the first slot of the run is returned as a token. Execution units later present that token to mark the instruction as executed.

On every cycle the queue looks at the oldest entry and retires entries strictly in program order. It stops at the first entry that has not executed, when the queue runs empty, or when a run-time per-cycle cap is reached. A cap of zero removes the limit. Retired instruction identifiers appear on a set of output lanes, oldest in the lowest lane. Each retirement returns that entry's slots to the free pool. The free-slot count and an empty flag are visible at all times.

Top module: `rq_retire_queue`

## Requirements
- R1: After a synchronous active-high reset, freeSlots equals DEPTH, empty is 1, no retire lane is valid and resvToken is 0.
- R2: The slot count taken by a reservation is 1 when resvUops is 0, DEPTH when resvUops exceeds DEPTH, and resvUops otherwise.
- R3: resvToken shows the index where the next reservation starts. An accepted reservation moves it forward by the normalized count, modulo DEPTH.
- R4: resvReady is 1 exactly when freeSlots is at least the normalized count. A request made while resvReady is 0 changes neither freeSlots nor resvToken.
- R5: freeSlots falls by the normalized count of each accepted reservation and rises by the slot count of each retired entry. empty is 1 exactly when freeSlots equals DEPTH.
- R6: Retirement proceeds from the oldest entry in program order. It stops at the first entry not yet marked executed, and no younger entry retires past it.
- R7: With retireLimit nonzero, at most retireLimit entries retire in one cycle. With retireLimit 0, every consecutive executed entry from the head retires in the same cycle.
- R8: Retire lanes are filled from lane 0 upward with no gaps. Lane k carries in retireId bits [k*ID_W +: ID_W] the identifier given at reservation.
- R9: A mark presented in cycle t makes its entry retirable in cycle t+1 and not in cycle t.
- R10: A reservation and a mark presented in the same cycle both take effect.
- R11: A mark names the first slot of a live, unexecuted entry and affects only that entry. Marking a younger entry while the head is unexecuted retires nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| resvValid | input | 1 | Reservation request |
| resvId | input | ID_W | Instruction identifier to store |
| resvUops | input | UOP_W | Requested micro-op count |
| resvReady | output | 1 | Enough free slots for the current request |
| resvToken | output | log2(DEPTH) | Token (first slot) a reservation this cycle receives |
| markValid | input | 1 | Executed-mark strobe |
| markToken | input | log2(DEPTH) | Token of the entry that finished execution |
| retireLimit | input | log2(DEPTH+1) | Per-cycle retire cap, 0 means no cap |
| retireValid | output | DEPTH | Per-lane retire valid, lane 0 oldest |
| retireId | output | DEPTH*ID_W | Per-lane retired identifiers |
| freeSlots | output | log2(DEPTH+1) | Number of unclaimed slots |
| empty | output | 1 | No slot is claimed |

## Verification
The inline assertions check on every cycle that:
- the retire lanes stay packed from lane 0 and never exceed a nonzero cap;
- the free count stays within the depth;
- the token steps by the normalized count after an accepted reservation and holds after a refused one;
- marks only hit live, unexecuted entries;
- a reservation never lands on a live entry.

The stall behind an unexecuted head, the one-cycle delay from mark to retirement, clamping of zero and oversize requests, and a reservation and a mark landing together can only be shown by the bench. It runs those directed sequences and then a long random mix against an in-order reference model.

// File: rtl/rq_pkg.sv
`timescale 1ns/1ps
package rq_pkg;
  // strobes the control raises toward the entry store
  typedef struct packed {
    logic resvWe;   // write a new entry at resvIdx
    logic markWe;   // set executed flag at markIdx
  } rqStrobe_t;
endpackage

// File: rtl/rq_store.sv
`timescale 1ns/1ps
module rq_store
  import rq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int ID_W  = 8,
  parameter int IDX_W = 4,
  parameter int CNT_W = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  rqStrobe_t               strb,
  input  logic [IDX_W-1:0]        resvIdx,
  input  logic [CNT_W-1:0]        resvCnt,
  input  logic [ID_W-1:0]         resvId,
  input  logic [IDX_W-1:0]        markIdx,
  input  logic [DEPTH-1:0]        retireMask,
  output logic [DEPTH-1:0]        validVec,
  output logic [DEPTH-1:0]        execVec,
  output logic [DEPTH*CNT_W-1:0]  slotCnt,
  output logic [DEPTH*ID_W-1:0]   slotId
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic hitResv, hitMark;
    assign hitResv = strb.resvWe && (int'(resvIdx) == i);
    assign hitMark = strb.markWe && (int'(markIdx) == i);

    always_ff @(posedge clk) begin
      if (rst) begin
        validVec[i] <= 1'b0;
        execVec[i]  <= 1'b0;
      end else begin
        if (retireMask[i]) begin
          validVec[i] <= 1'b0;
          execVec[i]  <= 1'b0;
        end
        if (hitResv) begin
          validVec[i] <= 1'b1;
          execVec[i]  <= 1'b0;
        end
        if (hitMark) execVec[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (hitResv) begin
        slotCnt[i*CNT_W +: CNT_W] <= resvCnt;
        slotId[i*ID_W +: ID_W]    <= resvId;
      end
    end
  end

  // R11: a mark must hit the head slot of a live entry that has not executed yet
  p_mark_live_r11: assert property (@(posedge clk) disable iff (rst)
    strb.markWe |-> (validVec[markIdx] && !execVec[markIdx]));

  // R10: a reservation never overwrites a live entry
  p_resv_free_slot_r10: assert property (@(posedge clk) disable iff (rst)
    strb.resvWe |-> !validVec[resvIdx]);

endmodule

// File: rtl/rq_ctrl.sv
`timescale 1ns/1ps
module rq_ctrl
  import rq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int ID_W  = 8,
  parameter int UOP_W = 6,
  parameter int IDX_W = 4,
  parameter int CNT_W = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    resvValid,
  input  logic [UOP_W-1:0]        resvUops,
  output logic                    resvReady,
  output logic [IDX_W-1:0]        resvToken,
  input  logic                    markValid,
  input  logic [IDX_W-1:0]        markToken,
  input  logic [CNT_W-1:0]        retireLimit,
  input  logic [DEPTH-1:0]        validVec,
  input  logic [DEPTH-1:0]        execVec,
  input  logic [DEPTH*CNT_W-1:0]  slotCnt,
  input  logic [DEPTH*ID_W-1:0]   slotId,
  output rqStrobe_t               strb,
  output logic [CNT_W-1:0]        resvCnt,
  output logic [IDX_W-1:0]        markIdx,
  output logic [DEPTH-1:0]        retireMask,
  output logic [DEPTH-1:0]        retireValid,
  output logic [DEPTH*ID_W-1:0]   retireId,
  output logic [CNT_W-1:0]        freeSlots,
  output logic                    empty
);

  logic [IDX_W-1:0] headQ, tailQ, headNext;
  logic [CNT_W-1:0] freeQ, freedSlots;
  logic             accept;

  function automatic logic [IDX_W-1:0] stepIdx(input logic [IDX_W-1:0] p,
                                               input logic [CNT_W-1:0] n);
    int s;
    s = int'(p) + int'(n);
    if (s >= DEPTH) s = s - DEPTH;
    return IDX_W'(s);
  endfunction

  // normalize requested micro-ops into a slot count in [1, DEPTH]
  always_comb begin
    int u;
    u = int'(resvUops);
    if (u == 0)         u = 1;
    else if (u > DEPTH) u = DEPTH;
    resvCnt = CNT_W'(u);
  end

  assign resvReady   = (freeQ >= resvCnt);
  assign accept      = resvValid && resvReady;
  assign resvToken   = tailQ;
  assign markIdx     = markToken;
  assign strb.resvWe = accept;
  assign strb.markWe = markValid;
  assign freeSlots   = freeQ;
  assign empty       = (int'(freeQ) == DEPTH);

  // in-order walk from the head across executed entries
  always_comb begin
    logic [IDX_W-1:0] p;
    logic [CNT_W-1:0] c;
    int left;
    int freed;
    logic go;
    p = headQ;
    left = DEPTH - int'(freeQ);
    freed = 0;
    go = 1'b1;
    retireMask  = '0;
    retireValid = '0;
    retireId    = '0;
    for (int k = 0; k < DEPTH; k++) begin
      c = slotCnt[int'(p)*CNT_W +: CNT_W];
      if (go && left > 0 && validVec[p] && execVec[p] &&
          (retireLimit == '0 || k < int'(retireLimit))) begin
        retireValid[k]              = 1'b1;
        retireId[k*ID_W +: ID_W]    = slotId[int'(p)*ID_W +: ID_W];
        retireMask[p]               = 1'b1;
        freed                       = freed + int'(c);
        left                        = left - int'(c);
        p                           = stepIdx(p, c);
      end else begin
        go = 1'b0;
      end
    end
    headNext   = p;
    freedSlots = CNT_W'(freed);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      headQ <= '0;
      tailQ <= '0;
      freeQ <= CNT_W'(DEPTH);
    end else begin
      headQ <= headNext;
      if (accept) tailQ <= stepIdx(tailQ, resvCnt);
      freeQ <= freeQ - (accept ? resvCnt : '0) + freedSlots;
    end
  end

  // R5: free count never exceeds the depth
  p_free_bound_r5: assert property (@(posedge clk) disable iff (rst)
    int'(freeSlots) <= DEPTH);

  // R5: nothing retires from an empty queue
  p_empty_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    empty |-> (retireValid == '0));

  // R8: lanes packed from lane 0 with no holes
  p_lanes_packed_r8: assert property (@(posedge clk) disable iff (rst)
    ((retireValid & (retireValid + 1'b1)) == '0));

  // R7: a nonzero cap bounds the retirements of the cycle
  p_retire_cap_r7: assert property (@(posedge clk) disable iff (rst)
    (retireLimit != '0) |-> ($countones(retireValid) <= int'(retireLimit)));

  // R3: token steps by the normalized count after an accepted reservation
  p_token_step_r3: assert property (@(posedge clk) disable iff (rst)
    (resvValid && resvReady) |=>
      (int'(resvToken) == (int'($past(resvToken)) + int'($past(resvCnt))) % DEPTH));

  // R4: a refused request leaves the token where it was
  p_refused_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (resvValid && !resvReady) |=> (resvToken == $past(resvToken)));

endmodule

// File: rtl/rq_retire_queue.sv
`timescale 1ns/1ps
module rq_retire_queue
  import rq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int ID_W  = 8,
  parameter int UOP_W = 6,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   resvValid,
  input  logic [ID_W-1:0]        resvId,
  input  logic [UOP_W-1:0]       resvUops,
  output logic                   resvReady,
  output logic [IDX_W-1:0]       resvToken,
  input  logic                   markValid,
  input  logic [IDX_W-1:0]       markToken,
  input  logic [CNT_W-1:0]       retireLimit,
  output logic [DEPTH-1:0]       retireValid,
  output logic [DEPTH*ID_W-1:0]  retireId,
  output logic [CNT_W-1:0]       freeSlots,
  output logic                   empty
);

  rqStrobe_t               strb;
  logic [IDX_W-1:0]        markIdx;
  logic [CNT_W-1:0]        resvCnt;
  logic [DEPTH-1:0]        retireMask, validVec, execVec;
  logic [DEPTH*CNT_W-1:0]  slotCnt;
  logic [DEPTH*ID_W-1:0]   slotId;

  rq_ctrl #(.DEPTH(DEPTH), .ID_W(ID_W), .UOP_W(UOP_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .resvValid(resvValid), .resvUops(resvUops), .resvReady(resvReady), .resvToken(resvToken),
    .markValid(markValid), .markToken(markToken), .retireLimit(retireLimit),
    .validVec(validVec), .execVec(execVec), .slotCnt(slotCnt), .slotId(slotId),
    .strb(strb), .resvCnt(resvCnt), .markIdx(markIdx), .retireMask(retireMask),
    .retireValid(retireValid), .retireId(retireId), .freeSlots(freeSlots), .empty(empty)
  );

  rq_store #(.DEPTH(DEPTH), .ID_W(ID_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst(rst), .strb(strb),
    .resvIdx(resvToken), .resvCnt(resvCnt), .resvId(resvId),
    .markIdx(markIdx), .retireMask(retireMask),
    .validVec(validVec), .execVec(execVec), .slotCnt(slotCnt), .slotId(slotId)
  );

endmodule

// File: tb/rq_retire_queue_bench.sv
`timescale 1ns/1ps
module rq_retire_queue_bench;
  localparam int DEPTH = 16;
  localparam int ID_W  = 8;
  localparam int UOP_W = 6;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst;
  logic resvValid, markValid;
  logic [ID_W-1:0] resvId;
  logic [UOP_W-1:0] resvUops;
  logic [IDX_W-1:0] markToken, resvToken;
  logic [CNT_W-1:0] retireLimit, freeSlots;
  logic resvReady, empty;
  logic [DEPTH-1:0] retireValid;
  logic [DEPTH*ID_W-1:0] retireId;

  always #5 clk = ~clk;

  rq_retire_queue #(.DEPTH(DEPTH), .ID_W(ID_W), .UOP_W(UOP_W)) u_rq_retire_queue (
    .clk(clk), .rst(rst), .resvValid(resvValid), .resvId(resvId), .resvUops(resvUops),
    .resvReady(resvReady), .resvToken(resvToken), .markValid(markValid), .markToken(markToken),
    .retireLimit(retireLimit), .retireValid(retireValid), .retireId(retireId),
    .freeSlots(freeSlots), .empty(empty)
  );

  int total = 0, bad = 0;
  bit finished = 1'b0;

  // reference model
  logic [ID_W-1:0] mId [DEPTH];
  int  mCnt [DEPTH];
  bit  mVal [DEPTH];
  bit  mExe [DEPTH];
  int  mHead, mTail, mFree;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int normCnt(input int u);
    if (u == 0) return 1;
    if (u > DEPTH) return DEPTH;
    return u;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < DEPTH; i++) begin
      mVal[i] = 0; mExe[i] = 0; mCnt[i] = 0; mId[i] = '0;
    end
    mHead = 0; mTail = 0; mFree = DEPTH;
  endtask

  // one cycle: drive at negedge, check, then advance the model to the next edge
  task automatic doCycle(input bit rv, input logic [ID_W-1:0] rid, input int ru,
                         input bit mv, input int mt, input int lim);
    int need, n, p, maxRet;
    bit expReady;
    logic [DEPTH-1:0] eValid;
    logic [ID_W-1:0] eId [DEPTH];
    @(negedge clk);
    resvValid = rv; resvId = rid; resvUops = UOP_W'(ru);
    markValid = mv; markToken = IDX_W'(mt); retireLimit = CNT_W'(lim);
    #1;
    need = normCnt(ru);
    expReady = (mFree >= need);
    eValid = '0;
    n = 0; p = mHead;
    maxRet = (lim == 0) ? DEPTH : lim;
    while (n < maxRet && mFree + 0 < DEPTH && mVal[p] && mExe[p]) begin
      eValid[n] = 1'b1; eId[n] = mId[p];
      n++;
      p = (p + mCnt[p]) % DEPTH;
      if (p == mTail) break;
    end
    chk(int'(resvToken) == mTail, "R3 token", resvToken, mTail);
    chk(resvReady == expReady, "R4 ready", resvReady, expReady);
    chk(int'(freeSlots) == mFree, "R5 free", freeSlots, mFree);
    chk(empty == (mFree == DEPTH), "R5 empty", empty, mFree == DEPTH);
    chk(retireValid == eValid, "R6 R7 retire lanes", retireValid, eValid);
    for (int k = 0; k < n; k++)
      chk(retireId[k*ID_W +: ID_W] == eId[k], "R8 lane id", retireId[k*ID_W +: ID_W], eId[k]);
    // model update for the coming edge
    for (int k = 0; k < n; k++) begin
      mVal[mHead] = 0; mExe[mHead] = 0;
      mFree += mCnt[mHead];
      mHead = (mHead + mCnt[mHead]) % DEPTH;
    end
    if (rv && expReady) begin
      mVal[mTail] = 1; mExe[mTail] = 0; mCnt[mTail] = need; mId[mTail] = rid;
      mTail = (mTail + need) % DEPTH;
      mFree -= need;
    end
    if (mv) mExe[mt] = 1;
  endtask

  task automatic idle(input int lim);
    doCycle(0, '0, 0, 0, 0, lim);
  endtask

  function automatic int pickMark(input int start);
    for (int i = 0; i < DEPTH; i++) begin
      int j;
      j = (start + i) % DEPTH;
      if (mVal[j] && !mExe[j]) return j;
    end
    return -1;
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lim, cand;
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; resvValid = 0; resvId = '0; resvUops = '0;
    markValid = 0; markToken = '0; retireLimit = '0;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; #1;
    // R1 reset state
    chk(int'(freeSlots) == DEPTH, "R1 free", freeSlots, DEPTH);
    chk(empty == 1'b1, "R1 empty", empty, 1);
    chk(retireValid == '0, "R1 retire", retireValid, 0);
    chk(resvToken == '0, "R1 token", resvToken, 0);

    // R2 zero micro-ops still takes one slot
    doCycle(1, 8'h11, 0, 0, 0, 0);
    idle(0);
    chk(int'(freeSlots) == DEPTH - 1, "R2 zero uop", freeSlots, DEPTH - 1);
    doCycle(1, 8'h22, 3, 0, 0, 0);             // token 1
    // R10 reservation and mark in the same cycle; R11 younger mark while head waits
    doCycle(1, 8'h33, 2, 1, 1, 0);             // token 4, mark token 1
    idle(0);
    chk(int'(freeSlots) == DEPTH - 6, "R10 both effects free", freeSlots, DEPTH - 6);
    chk(retireValid == '0, "R11 younger mark retires nothing", retireValid, 0);
    // R9 mark head; no retire in the same cycle
    doCycle(0, '0, 0, 1, 0, 0);
    chk(retireValid == '0, "R9 same cycle", retireValid, 0);
    idle(0);
    chk(retireValid == 16'h0003, "R9 next cycle", retireValid, 3);
    chk(retireId[ID_W +: ID_W] == 8'h22, "R11 marked entry id", retireId[ID_W +: ID_W], 8'h22);
    doCycle(0, '0, 0, 1, 4, 0);
    idle(0); idle(0);
    chk(empty == 1'b1, "R5 drained", empty, 1);
    // R2 oversize clamps to DEPTH
    doCycle(1, 8'h44, 40, 0, 0, 0);            // token 6
    idle(0);
    chk(freeSlots == '0, "R2 oversize clamp", freeSlots, 0);
    doCycle(1, 8'h55, 0, 0, 0, 0);             // refused
    chk(resvReady == 1'b0, "R4 full refuses", resvReady, 0);
    idle(0);
    chk(resvToken == IDX_W'(6), "R4 refused no token move", resvToken, 6);
    chk(freeSlots == '0, "R4 refused no free change", freeSlots, 0);
    doCycle(0, '0, 0, 1, 6, 0);
    idle(0); idle(0);
    // R7 cap of two: five single-slot entries marked youngest first
    for (int i = 0; i < 5; i++) doCycle(1, ID_W'(8'h60 + i), 1, 0, 0, 2);
    for (int i = 4; i >= 0; i--) doCycle(0, '0, 0, 1, (6 + i) % DEPTH, 2);
    chk($countones(retireValid) == 0, "R7 before head mark", $countones(retireValid), 0);
    idle(2);
    chk($countones(retireValid) == 2, "R7 cap two", $countones(retireValid), 2);
    idle(2); idle(2); idle(2);
    chk(empty == 1'b1, "R7 cap drained", empty, 1);

    // random mix
    for (int it = 0; it < 4000; it++) begin
      int ru;
      bit rv, mv;
      if (it % 64 == 0) lim = $urandom % 5;
      rv = ($urandom % 3) != 0;
      ru = (($urandom % 10) == 0) ? 17 + $urandom % 8 : $urandom % 6;
      cand = pickMark($urandom % DEPTH);
      mv = (cand >= 0) && (($urandom % 2) == 0);
      doCycle(rv, ID_W'($urandom), ru, mv, mv ? cand : 0, lim);
    end
    // drain
    for (int it = 0; it < 200; it++) begin
      cand = pickMark(0);
      doCycle(0, '0, 0, cand >= 0, (cand >= 0) ? cand : 0, 0);
    end
    chk(empty == 1'b1, "R5 final empty", empty, 1);
    chk(int'(freeSlots) == DEPTH, "R5 final free", freeSlots, DEPTH);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule